// File: doc/BRIEF.md
# Thread-Context Tagged Cache Lookup

This block holds the tag, valid, context and replacement state of a small two-way set-associative data cache shared by two hardware threads. Each cycle it can accept one lookup, made of a thread number and a linear address. From each thread's page-table base value and paging-mode code it derives a one-bit context identifier for the requester. One cycle later it reports the result: hit or miss, whether an alias was resolved, the way used, the requester's context, and whether a valid line was evicted. On a miss it fills a line with the address tag and the requester's context. Data storage, translation and coherence live elsewhere.

A configuration bit selects between two sharing policies. In the shared policy, a tag match alone gives a hit, so one thread can alias another thread's line. In the adaptive policy, a hit also needs the stored context to equal the requester's. The two threads have the same context only when both their bases and their paging modes agree. A strap input reports whether policy selection is supported. When the strap is low, the shared policy is always used.

Top module: `ctxc_lookup`

## Requirements
- R1: While rst_n is low at a clock edge, every line becomes invalid and every replacement bit becomes 0; afterwards rsp_valid, rsp_hit, rsp_alias and rsp_evict are low until a lookup is answered.
- R2: A lookup presented with req_valid high at a clock edge is answered by rsp_valid high after that same edge. With req_valid low, rsp_valid is low after the edge and no cache state changes.
- R3: The requester's context, reported on rsp_ctx, is 0 when the two base values are equal and the two paging-mode codes are equal. Otherwise it is 0 for thread 0 and 1 for thread 1. It is computed from the inputs present in the lookup cycle.
- R4: In shared policy, a lookup hits a valid line in its set whose tag equals address bits [ADDR_W-1:OFF_W+SET_W], whatever context that line stores. Set index is address bits [OFF_W+SET_W-1:OFF_W].
- R5: In shared policy, a hit whose line stores a context different from the requester's sets rsp_alias for that one response. The line is then retagged to the requester's context, so the next lookup by the same requester under the same inputs hits without an alias. If a matching line with equal context exists, that line is chosen and no alias is flagged.
- R6: In adaptive policy, a lookup hits only a valid line whose tag and stored context both equal the requester's; rsp_alias is never set.
- R7: When cap_select is low, mode_adaptive has no effect and the shared policy applies.
- R8: On a miss, way 0 is filled if invalid, else way 1 if invalid, else the way named by the set's replacement bit. rsp_way reports the filled way, rsp_evict is high exactly when the filled way held a valid line, and the line stores tag and requester context.
- R9: After every hit or fill, the set's replacement bit names the way that was not used (0 for way 1, 1 for way 0).
- R10: A change of base values or paging modes never invalidates lines; lines whose stored context no longer equals the requester's just miss in adaptive policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_select | input | 1 | Strap: policy selection supported |
| mode_adaptive | input | 1 | 1 selects adaptive policy, 0 (reset preference) shared |
| base_t0 | input | BASE_W | Thread 0 page-table base value |
| base_t1 | input | BASE_W | Thread 1 page-table base value |
| pmode_t0 | input | PMODE_W | Thread 0 paging-mode code |
| pmode_t1 | input | PMODE_W | Thread 1 paging-mode code |
| req_valid | input | 1 | Lookup request present |
| req_thread | input | 1 | Requesting thread |
| req_addr | input | ADDR_W | Linear address of lookup |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_alias | output | 1 | Hit on a line of a different context (shared policy) |
| rsp_way | output | 1 | Way hit or filled |
| rsp_ctx | output | 1 | Requester context used |
| rsp_evict | output | 1 | Fill replaced a valid line |

## Verification
The bench builds the block with its defaults: 16-bit addresses, 4-byte lines, four sets, 8-bit bases and 2-bit paging modes. With four sets and two ways, a three-tag conflict sequence reaches replacement, eviction and replacement-bit updates in every set quickly. The bench sweeps all sixteen combinations of strap, policy bit, base equality and paging-mode equality. Each combination runs the same cross-thread sequence and then changes the bases without a flush, so aliasing, retagging, context isolation and the stale-context miss are all covered.

// File: rtl/ctxc_pkg.sv
// Package: shared types of the context-tagged lookup.
// Assumes a fixed associativity of two ways.
package ctxc_pkg;
    localparam int NUM_WAYS = 2;

    // Outcome of one tag comparison across the ways of a set.
    typedef enum logic [1:0] {
        LK_MISS  = 2'd0,
        LK_HIT   = 2'd1,
        LK_ALIAS = 2'd2
    } lookup_kind_e;
endpackage

// File: rtl/ctxc_ctx_gen.sv
// Module: derives the one-bit context of the requesting thread.
// Contexts are identical (both 0) when bases and paging modes agree;
// otherwise thread 1 takes context 1. Purely combinational.
module ctxc_ctx_gen #(
    parameter int BASE_W  = 8,
    parameter int PMODE_W = 2
) (
    input  logic [BASE_W-1:0]  base_t0,
    input  logic [BASE_W-1:0]  base_t1,
    input  logic [PMODE_W-1:0] pmode_t0,
    input  logic [PMODE_W-1:0] pmode_t1,
    input  logic               thread,
    output logic               ctx_same,
    output logic               req_ctx
);
    // Compare the translation state of both threads.
    always_comb begin
        ctx_same = (base_t0 == base_t1) && (pmode_t0 == pmode_t1);
        req_ctx  = thread && !ctx_same;
    end
endmodule

// File: rtl/ctxc_match.sv
// Module: compares one set's ways against a request and picks a way.
// Assumes two ways. Equal-context matches win over alias matches;
// lower way wins among equals. Aliases only count in shared policy.
module ctxc_match
    import ctxc_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic [NUM_WAYS-1:0]            way_valid,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [NUM_WAYS-1:0]            way_ctx,
    input  logic [TAG_W-1:0]               req_tag,
    input  logic                           req_ctx,
    input  logic                           adaptive,
    output lookup_kind_e                   kind,
    output logic                           hit_way
);
    logic [NUM_WAYS-1:0] tag_eq;
    logic [NUM_WAYS-1:0] ctx_eq;

    // Per-way comparators.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign tag_eq[w] = way_valid[w] && (way_tag[w] == req_tag);
        assign ctx_eq[w] = tag_eq[w] && (way_ctx[w] == req_ctx);
    end

    // Select hit kind and way with priority.
    always_comb begin
        kind    = LK_MISS;
        hit_way = 1'b0;
        if (ctx_eq[0]) begin
            kind = LK_HIT;
        end else if (ctx_eq[1]) begin
            kind    = LK_HIT;
            hit_way = 1'b1;
        end else if (!adaptive && tag_eq[0]) begin
            kind = LK_ALIAS;
        end else if (!adaptive && tag_eq[1]) begin
            kind    = LK_ALIAS;
            hit_way = 1'b1;
        end
    end
endmodule

// File: rtl/ctxc_tag_store.sv
// Module: valid, tag, context and replacement state of all sets.
// One combinational read port and one write port; the replacement
// bit has its own write enable. Reset is synchronous, active-low,
// and clears valid and replacement bits only.
module ctxc_tag_store
    import ctxc_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int TAG_W = 12,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SET_W-1:0]               rd_set,
    output logic [NUM_WAYS-1:0]            rd_valid,
    output logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag,
    output logic [NUM_WAYS-1:0]            rd_ctx,
    output logic                           rd_lru,
    input  logic                           wr_en,
    input  logic [SET_W-1:0]               wr_set,
    input  logic                           wr_way,
    input  logic [TAG_W-1:0]               wr_tag,
    input  logic                           wr_ctx,
    input  logic                           lru_en,
    input  logic                           lru_val
);
    logic [NUM_WAYS-1:0]            valid_q [SETS];
    logic [NUM_WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [NUM_WAYS-1:0]            ctx_q   [SETS];
    logic                           lru_q   [SETS];

    // Read the addressed set.
    always_comb begin
        rd_valid = valid_q[rd_set];
        rd_tag   = tag_q[rd_set];
        rd_ctx   = ctx_q[rd_set];
        rd_lru   = lru_q[rd_set];
    end

    // Valid and replacement state with reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lru_q[s]   <= 1'b0;
            end
        end else begin
            if (wr_en) valid_q[wr_set][wr_way] <= 1'b1;
            if (lru_en) lru_q[wr_set] <= lru_val;
        end
    end

    // Tag and context payload, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
            ctx_q[wr_set][wr_way] <= wr_ctx;
        end
    end
endmodule

// File: rtl/ctxc_lookup.sv
// Module: top of the context-tagged lookup for two threads.
// One lookup per cycle; result registered one cycle later. State is
// updated on the same edge that registers the result. Assumes
// OFF_W >= 1 and a power-of-two set count.
module ctxc_lookup
    import ctxc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int OFF_W   = 2,
    parameter int SETS    = 4,
    parameter int BASE_W  = 8,
    parameter int PMODE_W = 2,
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_select,
    input  logic               mode_adaptive,
    input  logic [BASE_W-1:0]  base_t0,
    input  logic [BASE_W-1:0]  base_t1,
    input  logic [PMODE_W-1:0] pmode_t0,
    input  logic [PMODE_W-1:0] pmode_t1,
    input  logic               req_valid,
    input  logic               req_thread,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_alias,
    output logic               rsp_way,
    output logic               rsp_ctx,
    output logic               rsp_evict
);
    logic [SET_W-1:0]               set_idx;
    logic [TAG_W-1:0]               req_tag;
    logic                           unused_offset;
    logic                           adaptive;
    logic                           ctx_same;
    logic                           req_ctx;
    logic [NUM_WAYS-1:0]            rd_valid;
    logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [NUM_WAYS-1:0]            rd_ctx;
    logic                           rd_lru;
    lookup_kind_e                   kind;
    logic                           hit_way;
    logic                           victim;
    logic                           use_way;
    logic                           wr_en;

    // Split the address; offset bits do not take part.
    always_comb begin
        set_idx       = req_addr[OFF_W +: SET_W];
        req_tag       = req_addr[ADDR_W-1 -: TAG_W];
        unused_offset = ^req_addr[OFF_W-1:0];
        adaptive      = cap_select && mode_adaptive;
    end

    ctxc_ctx_gen #(.BASE_W(BASE_W), .PMODE_W(PMODE_W)) u_ctx (
        .base_t0 (base_t0),
        .base_t1 (base_t1),
        .pmode_t0(pmode_t0),
        .pmode_t1(pmode_t1),
        .thread  (req_thread),
        .ctx_same(ctx_same),
        .req_ctx (req_ctx)
    );

    ctxc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (set_idx),
        .rd_valid(rd_valid),
        .rd_tag  (rd_tag),
        .rd_ctx  (rd_ctx),
        .rd_lru  (rd_lru),
        .wr_en   (wr_en),
        .wr_set  (set_idx),
        .wr_way  (use_way),
        .wr_tag  (req_tag),
        .wr_ctx  (req_ctx),
        .lru_en  (req_valid),
        .lru_val (!use_way)
    );

    ctxc_match #(.TAG_W(TAG_W)) u_match (
        .way_valid(rd_valid),
        .way_tag  (rd_tag),
        .way_ctx  (rd_ctx),
        .req_tag  (req_tag),
        .req_ctx  (req_ctx),
        .adaptive (adaptive),
        .kind     (kind),
        .hit_way  (hit_way)
    );

    // Choose the fill victim and the way written this cycle.
    always_comb begin
        if (!rd_valid[0])      victim = 1'b0;
        else if (!rd_valid[1]) victim = 1'b1;
        else                   victim = rd_lru;
        use_way = (kind == LK_MISS) ? victim : hit_way;
        wr_en   = req_valid && (kind != LK_HIT);
    end

    // Register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_alias <= 1'b0;
            rsp_way   <= 1'b0;
            rsp_ctx   <= 1'b0;
            rsp_evict <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && (kind != LK_MISS);
            rsp_alias <= req_valid && (kind == LK_ALIAS);
            rsp_way   <= req_valid && use_way;
            rsp_ctx   <= req_valid && req_ctx;
            rsp_evict <= req_valid && (kind == LK_MISS) && rd_valid[victim];
        end
    end

    logic unused_same;
    assign unused_same = ctx_same;
endmodule

// File: rtl/ctxc_lookup_chk.sv
// Module: protocol checker for ctxc_lookup, attached by bind.
module ctxc_lookup_chk (
    input logic clk,
    input logic rst_n,
    input logic cap_select,
    input logic mode_adaptive,
    input logic req_valid,
    input logic req_thread,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_alias,
    input logic rsp_ctx,
    input logic rsp_evict
);
    // R2: a request is answered after the next edge.
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2: no request, no response.
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R1: result flags stay low without a response.
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_alias || rsp_evict));
    // R5: an alias is always a hit.
    a_r5_alias_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_alias |-> rsp_hit);
    // R6: adaptive policy never reports an alias.
    a_r6_adaptive_no_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cap_select && mode_adaptive) |=> !rsp_alias);
    // R3: context 1 only for thread 1.
    a_r3_ctx_thread: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_thread) |=> !rsp_ctx);
    // R8: eviction only on a miss.
    a_r8_evict_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_evict |-> !rsp_hit);
endmodule

bind ctxc_lookup ctxc_lookup_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_select   (cap_select),
    .mode_adaptive(mode_adaptive),
    .req_valid    (req_valid),
    .req_thread   (req_thread),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_alias    (rsp_alias),
    .rsp_ctx      (rsp_ctx),
    .rsp_evict    (rsp_evict)
);

// File: tb/ctxc_lookup_test.sv
module ctxc_lookup_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_select = 1'b0;
    logic       mode_adaptive = 1'b0;
    logic [7:0] base_t0 = '0, base_t1 = '0;
    logic [1:0] pmode_t0 = '0, pmode_t1 = '0;
    logic       req_valid = 1'b0;
    logic       req_thread = 1'b0;
    logic [15:0] req_addr = '0;
    logic rsp_valid, rsp_hit, rsp_alias, rsp_way, rsp_ctx, rsp_evict;

    int tests = 0;
    int fails = 0;

    // Reference state: 4 sets, 2 ways.
    logic       m_v [4][2];
    logic [11:0] m_t [4][2];
    logic       m_c [4][2];
    logic       m_l [4];

    always #4 clk = ~clk;

    ctxc_lookup uut (
        .clk(clk), .rst_n(rst_n), .cap_select(cap_select),
        .mode_adaptive(mode_adaptive), .base_t0(base_t0), .base_t1(base_t1),
        .pmode_t0(pmode_t0), .pmode_t1(pmode_t1), .req_valid(req_valid),
        .req_thread(req_thread), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_alias(rsp_alias), .rsp_way(rsp_way),
        .rsp_ctx(rsp_ctx), .rsp_evict(rsp_evict)
    );

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: reset, then verify quiet outputs.
    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            m_l[s] = 1'b0;
            for (int w = 0; w < 2; w++) m_v[s][w] = 1'b0;
        end
        @(negedge clk);
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 flags", {rsp_hit, rsp_alias, rsp_evict}, 0);
    endtask

    // One lookup; expectation from the requirements.
    task automatic access(logic thr, logic [15:0] addr);
        logic diff, rc, adapt, e_hit, e_alias, e_way, e_evict;
        int   s;
        logic [11:0] t;
        logic [1:0] loose, exact;
        s     = int'(addr[3:2]);
        t     = addr[15:4];
        diff  = (base_t0 != base_t1) || (pmode_t0 != pmode_t1);
        rc    = thr & diff;                        // R3
        adapt = cap_select & mode_adaptive;        // R7
        for (int w = 0; w < 2; w++) begin
            loose[w] = m_v[s][w] && (m_t[s][w] == t);
            exact[w] = loose[w] && (m_c[s][w] == rc);
        end
        e_alias = 1'b0;
        e_evict = 1'b0;
        if (exact != 0) begin                      // R4 R6
            e_hit = 1'b1; e_way = !exact[0];
        end else if (!adapt && loose != 0) begin   // R5
            e_hit = 1'b1; e_alias = 1'b1; e_way = !loose[0];
        end else begin                             // R8
            e_hit = 1'b0;
            e_way = !m_v[s][0] ? 1'b0 : (!m_v[s][1] ? 1'b1 : m_l[s]);
            e_evict = m_v[s][e_way];
        end
        req_valid  = 1'b1;
        req_thread = thr;
        req_addr   = addr;
        @(negedge clk);
        req_valid  = 1'b0;
        check("R2 rsp_valid", rsp_valid, 1);
        check("R3 rsp_ctx", rsp_ctx, rc);
        check(adapt ? "R6 hit" : "R4 hit", rsp_hit, e_hit);
        check("R5 alias", rsp_alias, e_alias);
        check("R8 way", rsp_way, e_way);
        check("R8 evict", rsp_evict, e_evict);
        if (!e_hit || e_alias) begin
            m_v[s][e_way] = 1'b1; m_t[s][e_way] = t; m_c[s][e_way] = rc;
        end
        m_l[s] = !e_way;                           // R9
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int cfg = 0; cfg < 16; cfg++) begin
            do_reset();
            cap_select    = cfg[0];
            mode_adaptive = cfg[1];
            base_t0  = 8'h31;
            base_t1  = cfg[2] ? 8'h31 : 8'h77;
            pmode_t0 = 2'd1;
            pmode_t1 = cfg[3] ? 2'd1 : 2'd2;
            for (int s = 0; s < 4; s++) begin
                logic [15:0] a, b, c;
                a = {12'h100 + 12'(s), 2'(s), 2'b01};
                b = {12'h200 + 12'(s), 2'(s), 2'b10};
                c = {12'h300 + 12'(s), 2'(s), 2'b11};
                access(1'b0, a);
                access(1'b1, a);   // R4 R5 R6 R7 cross-thread
                access(1'b1, a);   // R5 retag then plain hit
                access(1'b0, a);
                access(1'b0, b);
                access(1'b1, c);   // R8 R9 replacement
                access(1'b0, a);
                // R2: idle cycle changes nothing and gives no response.
                @(negedge clk);
                check("R2 idle", rsp_valid, 0);
            end
            // R10: context change without flush.
            base_t1  = base_t0;
            pmode_t1 = pmode_t0;
            for (int s = 0; s < 4; s++) begin
                access(1'b1, {12'h100 + 12'(s), 2'(s), 2'b00});
                access(1'b1, {12'h300 + 12'(s), 2'(s), 2'b00});
            end
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule